// File: doc/BRIEF.md
# Isochronous Cycle Timer with Extended Bus Time

This block keeps the isochronous cycle timer of a serial-bus link layer. An enable input, `tick_en`, is asserted once per period of the nominal 24.576 MHz timebase. On each such tick the block advances a three-level count. The lowest level counts ticks within a cycle and rolls over after 3072 of them. The middle level counts cycles within a second and rolls over after 8000. The top level is a 7-bit seconds field that covers 128 seconds before it wraps. The three fields are presented together as one 32-bit word on `cycle_time`.

Software also needs a seconds count that does not wrap every two minutes. The block therefore keeps a 32-bit bus time. Its low 7 bits are always the live seconds field. Its upper 25 bits are held in a register. A stored shadow copy of the seconds MSB sits beside that register. Whenever the shadow and the live MSB disagree, the stored value is advanced by 64 and the shadow is brought back into agreement. Read data already includes a pending advance, so a read taken in the cycle right after the MSB flips is still correct. Each time the seconds field rolls from 127 to 0, the block emits a one-cycle event pulse and sets a sticky status bit.

A single-cycle write strobe with a 2-bit address gives access to four locations. Address 0 is the cycle-timer word, address 1 is the bus time, address 2 is the status, and address 3 is reserved. Read data is combinational from the address.

Top module: `iso_cycle_timer`

The block has no multi-state controller. Its behaviour is carried by three cascaded counters and one shadow-bit comparison. The only "transitions" are the counter wraps (tick to cycle, cycle to second, second wrap) and the shadow catch-up on a seconds-MSB change.

## Requirements
- R1: The cycle-timer word packs the tick offset in bits 11:0, the cycle count in bits 24:12 and the seconds in bits 31:25. After reset the word is 0, a bus-time read returns 0 and the status bit is 0.
- R2: Each cycle with `tick_en` high and no cycle-timer write advances the tick offset by one. An offset of 3071 or more goes to 0 instead, and the cycle count advances on that same tick. With `tick_en` low and no write, the word holds.
- R3: When the offset wraps and the cycle count is 7999 or more, the count goes to 0 and the seconds field advances on the same tick. Seconds 127 advances to 0.
- R4: On the tick where seconds roll from 127 to 0, `sec64_pulse` is high for exactly the following cycle. On the same edge, status bit 0 (address 2) is set. It is cleared by a write to address 2 with data bit 0 at 1. A write with bit 0 at 0 has no effect, and a set on the same edge wins over a clear. Status bits 31:1 read 0.
- R5: A bus-time read (address 1) returns the full seconds count. Bits 6:0 equal the live seconds field. Bits 31:7 advance by one each time the seconds wrap from 127 to 0. This holds in every cycle, including the cycle directly after the seconds MSB changes.
- R6: A bus-time write replaces bits 31:7 only; bits 6:0 keep following the seconds field. A write on the same edge as a seconds wrap is applied before the wrap's carry, so the value read afterwards is the written upper bits plus one.
- R7: A cycle-timer write (address 0) loads all three fields from the write data and takes priority over a tick on the same edge. Bus-time bits 31:7 are kept, and bits 6:0 become the new seconds with no spurious advance.
- R8: Address 3 reads 0, and a write to it changes neither the word, the bus time nor the status.
- R9: `rst` is synchronous and active high, and it returns all state to the R1 values from any point of operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One pulse per timebase tick |
| reg_wr | input | 1 | Single-cycle register write strobe |
| reg_addr | input | 2 | 0 cycle word, 1 bus time, 2 status, 3 reserved |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| cycle_time | output | 32 | Packed seconds/cycle/offset word |
| sec64_pulse | output | 1 | One-cycle pulse after a seconds wrap |

## Verification
Some properties are checked on every cycle:
- the offset step on an ordinary tick;
- the word holding when idle;
- the event pulse lasting one cycle and coinciding with an all-zero word;
- the sticky bit being set while the pulse is visible;
- the low seven bus-time bits mirroring the seconds field;
- the reserved address reading zero.

Only the bench's scenarios show the following:
- the carry of the upper bus-time bits across a wrap, including the read in the cycle straight after the MSB flip;
- the ordering of a bus-time write against a simultaneous wrap;
- write priority over a tick;
- out-of-range loads folding back to zero.

The bench compares these against a seconds-count reference model that never represents the shadow bit.

// File: rtl/ict_pkg.sv
package ict_pkg;

    localparam int OFF_W = 12;
    localparam int CNT_W = 13;
    localparam int SEC_W = 7;
    localparam int WORD_W = OFF_W + CNT_W + SEC_W;
    localparam int BT_HI_W = WORD_W - SEC_W;

    typedef enum logic [1:0] {
        REG_CYCLE   = 2'd0,
        REG_BUSTIME = 2'd1,
        REG_STATUS  = 2'd2,
        REG_SPARE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [SEC_W-1:0] secs;
        logic [CNT_W-1:0] cycles;
        logic [OFF_W-1:0] ticks;
    } cycle_word_t;

endpackage

// File: rtl/ict_wrap_counter.sv
module ict_wrap_counter #(
    parameter int W   = 12,
    parameter int MOD = 3072
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] value,
    output logic         carry
);
    localparam logic [W-1:0] LAST = W'(MOD - 1);

    // at or beyond the last legal value the next step folds to zero
    assign carry = inc && (value >= LAST);

    always_ff @(posedge clk) begin
        if (rst)
            value <= '0;
        else if (load)
            value <= load_val;
        else if (inc)
            value <= carry ? '0 : value + W'(1);
    end
endmodule

// File: rtl/ict_bus_time.sv
module ict_bus_time #(
    parameter int HI_W = 25
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sec_msb,
    input  logic            ct_load,
    input  logic            ct_msb,
    input  logic            bt_wr,
    input  logic [HI_W-1:0] bt_wdata,
    output logic [HI_W-1:0] bt_upper
);
    // stored upper bits with the shadow of the seconds MSB as bit 0
    logic [HI_W:0] stored;
    logic [HI_W:0] caught_up;
    logic          pending;

    assign pending   = stored[0] ^ sec_msb;
    assign caught_up = stored + {{HI_W{1'b0}}, pending};
    assign bt_upper  = caught_up[HI_W:1];

    always_ff @(posedge clk) begin
        if (rst)
            stored <= '0;
        else if (ct_load)
            stored <= {caught_up[HI_W:1], ct_msb};
        else if (bt_wr)
            stored <= {bt_wdata, caught_up[0]};
        else
            stored <= caught_up;
    end
endmodule

// File: rtl/iso_cycle_timer.sv
module iso_cycle_timer #(
    parameter int TICKS_PER_CYCLE  = 3072,
    parameter int CYCLES_PER_SEC   = 8000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_en,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic [31:0] cycle_time,
    output logic        sec64_pulse
);
    import ict_pkg::*;

    localparam int SEC_MOD = 1 << SEC_W;

    reg_sel_e              sel;
    cycle_word_t           word;
    cycle_word_t           wr_word;
    logic                  ct_wr;
    logic                  bt_wr;
    logic                  st_clr;
    logic                  tick_go;
    logic                  off_carry;
    logic                  cnt_carry;
    logic                  sec_carry;
    logic                  sticky;
    logic [BT_HI_W-1:0]    bt_upper;

    assign sel     = reg_sel_e'(reg_addr);
    assign wr_word = cycle_word_t'(reg_wdata);
    assign ct_wr   = reg_wr && (sel == REG_CYCLE);
    assign bt_wr   = reg_wr && (sel == REG_BUSTIME);
    assign st_clr  = reg_wr && (sel == REG_STATUS) && reg_wdata[0];
    assign tick_go = tick_en && !ct_wr;

    ict_wrap_counter #(.W(OFF_W), .MOD(TICKS_PER_CYCLE)) u_ticks (
        .clk(clk), .rst(rst), .load(ct_wr), .load_val(wr_word.ticks),
        .inc(tick_go), .value(word.ticks), .carry(off_carry)
    );

    ict_wrap_counter #(.W(CNT_W), .MOD(CYCLES_PER_SEC)) u_cycles (
        .clk(clk), .rst(rst), .load(ct_wr), .load_val(wr_word.cycles),
        .inc(off_carry), .value(word.cycles), .carry(cnt_carry)
    );

    ict_wrap_counter #(.W(SEC_W), .MOD(SEC_MOD)) u_secs (
        .clk(clk), .rst(rst), .load(ct_wr), .load_val(wr_word.secs),
        .inc(cnt_carry), .value(word.secs), .carry(sec_carry)
    );

    ict_bus_time #(.HI_W(BT_HI_W)) u_bus_time (
        .clk(clk), .rst(rst), .sec_msb(word.secs[SEC_W-1]),
        .ct_load(ct_wr), .ct_msb(wr_word.secs[SEC_W-1]),
        .bt_wr(bt_wr), .bt_wdata(reg_wdata[31:SEC_W]),
        .bt_upper(bt_upper)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sec64_pulse <= 1'b0;
            sticky      <= 1'b0;
        end else begin
            sec64_pulse <= sec_carry;
            if (sec_carry)
                sticky <= 1'b1;
            else if (st_clr)
                sticky <= 1'b0;
        end
    end

    assign cycle_time = word;

    always_comb begin
        unique case (sel)
            REG_CYCLE:   reg_rdata = word;
            REG_BUSTIME: reg_rdata = {bt_upper, word.secs};
            REG_STATUS:  reg_rdata = {31'd0, sticky};
            REG_SPARE:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ict_checker.sv
module ict_checker (
    input logic        clk,
    input logic        rst,
    input logic        tick_en,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic [31:0] cycle_time,
    input logic        sec64_pulse
);
    logic ct_wr;
    assign ct_wr = reg_wr && (reg_addr == 2'd0);

    p_offset_step_r2: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !ct_wr && cycle_time[11:0] < 12'd3071)
        |=> cycle_time[11:0] == $past(cycle_time[11:0]) + 12'd1);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !reg_wr) |=> $stable(cycle_time));

    p_pulse_single_r4: assert property (@(posedge clk) disable iff (rst)
        sec64_pulse |=> !sec64_pulse);

    p_pulse_zero_word_r3: assert property (@(posedge clk) disable iff (rst)
        sec64_pulse |-> cycle_time == 32'd0);

    p_sticky_set_r4: assert property (@(posedge clk) disable iff (rst)
        (sec64_pulse && reg_addr == 2'd2) |-> reg_rdata[0]);

    p_bus_low_bits_r5: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 2'd1) |-> reg_rdata[6:0] == cycle_time[31:25]);

    p_spare_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 2'd3) |-> reg_rdata == 32'd0);

    p_status_upper_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 2'd2) |-> reg_rdata[31:1] == 31'd0);

    logic unused_ok;
    assign unused_ok = ^reg_wdata;
endmodule

bind iso_cycle_timer ict_checker u_ict_checker (
    .clk(clk), .rst(rst), .tick_en(tick_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cycle_time(cycle_time), .sec64_pulse(sec64_pulse)
);

// File: tb/iso_cycle_timer_test.sv
`timescale 1ns/1ps
module iso_cycle_timer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic [31:0] cycle_time;
    logic        sec64_pulse;

    int total = 0;
    int bad = 0;

    // reference model: plain integer counters and a full seconds count
    int          m_off, m_cnt, m_sec;
    logic [31:0] m_full;
    logic        m_pulse, m_sticky;

    always #4 clk = ~clk;

    iso_cycle_timer uut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cycle_time(cycle_time), .sec64_pulse(sec64_pulse)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] m_word();
        return {7'(m_sec), 13'(m_cnt), 12'(m_off)};
    endfunction

    function automatic logic [31:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return m_word();
            2'd1: return m_full;
            2'd2: return {31'd0, m_sticky};
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_edge(input bit r, input bit t, input bit w,
                              input logic [1:0] a, input logic [31:0] d);
        if (r) begin
            m_off = 0; m_cnt = 0; m_sec = 0; m_full = 0;
            m_pulse = 0; m_sticky = 0;
            return;
        end
        m_pulse = 0;
        if (w && a == 2'd1)
            m_full = {d[31:7], m_full[6:0]};
        if (w && a == 2'd0) begin
            m_off = int'(d[11:0]);
            m_cnt = int'(d[24:12]);
            m_sec = int'(d[31:25]);
            m_full = {m_full[31:7], d[31:25]};
        end else if (t) begin
            if (m_off >= 3071) begin
                m_off = 0;
                if (m_cnt >= 7999) begin
                    m_cnt = 0;
                    m_full = m_full + 32'd1;
                    if (m_sec == 127) begin
                        m_sec = 0;
                        m_pulse = 1;
                    end else begin
                        m_sec = m_sec + 1;
                    end
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end else begin
                m_off = m_off + 1;
            end
        end
        if (m_pulse)
            m_sticky = 1;
        else if (w && a == 2'd2 && d[0])
            m_sticky = 0;
    endtask

    task automatic step(input bit t, input bit w, input logic [1:0] a,
                        input logic [31:0] d);
        string tag;
        tick_en = t; reg_wr = w; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        model_edge(rst, t, w, a, d);
        #1;
        tick_en = 0; reg_wr = 0;
        chk(cycle_time == m_word(), "R2 word", cycle_time, m_word());
        chk(sec64_pulse == m_pulse, "R4 pulse", 32'(sec64_pulse), 32'(m_pulse));
        case (a)
            2'd0: tag = "R1 read word";
            2'd1: tag = "R5 read bus time";
            2'd2: tag = "R4 read status";
            default: tag = "R8 read spare";
        endcase
        chk(reg_rdata == m_read(a), tag, reg_rdata, m_read(a));
    endtask

    task automatic do_reset(input int n);
        rst = 1'b1;
        for (int i = 0; i < n; i++) step(1, 0, 2'd1, 32'd0);
        rst = 1'b0;
    endtask

    function automatic logic [31:0] ct(input int s, input int c, input int o);
        return {7'(s), 13'(c), 12'(o)};
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stimulus
        // R1 / R9: reset state
        do_reset(3);
        chk(cycle_time == 32'd0, "R1 reset word", cycle_time, 32'd0);
        step(0, 0, 2'd1, 32'd0);
        chk(reg_rdata == 32'd0, "R1 reset bus time", reg_rdata, 32'd0);

        // R2: continuous ticks then sparse ticks
        for (int i = 0; i < 12; i++) step(1, 0, 2'd0, 32'd0);
        chk(cycle_time == 32'd12, "R2 twelve ticks", cycle_time, 32'd12);
        for (int i = 0; i < 12; i++) step(i % 3 == 0, 0, 2'd0, 32'd0);

        // R2: offset wrap bumps cycle count
        step(0, 1, 2'd0, ct(0, 5, 3069));
        for (int i = 0; i < 4; i++) step(1, 0, 2'd0, 32'd0);
        chk(cycle_time == ct(0, 6, 1), "R2 offset wrap", cycle_time, ct(0, 6, 1));

        // R2: out-of-range offset folds on next tick
        step(0, 1, 2'd0, ct(2, 9, 4000));
        step(1, 0, 2'd0, 32'd0);
        chk(cycle_time == ct(2, 10, 0), "R2 offset fold", cycle_time, ct(2, 10, 0));

        // R3: count wrap bumps seconds; out-of-range count folds
        step(0, 1, 2'd0, ct(10, 7998, 3070));
        for (int i = 0; i < 4; i++) step(1, 0, 2'd0, 32'd0);
        step(0, 1, 2'd0, ct(20, 8191, 3071));
        step(1, 0, 2'd0, 32'd0);
        chk(cycle_time == ct(21, 0, 0), "R3 count fold", cycle_time, ct(21, 0, 0));

        // R5: MSB flip 63->64, read in the very next cycle
        do_reset(1);
        step(0, 1, 2'd0, ct(63, 7999, 3069));
        step(1, 0, 2'd1, 32'd0);
        step(1, 0, 2'd1, 32'd0);
        step(1, 0, 2'd1, 32'd0);
        chk(reg_rdata == 32'h40, "R5 read right after MSB flip", reg_rdata, 32'h40);

        // R4 / R5: seconds wrap 127->0
        step(0, 1, 2'd0, ct(127, 7999, 3071));
        step(1, 0, 2'd1, 32'd0);
        chk(sec64_pulse == 1'b1, "R4 pulse on wrap", 32'(sec64_pulse), 32'd1);
        chk(reg_rdata == 32'h80, "R5 carry into upper bits", reg_rdata, 32'h80);
        step(1, 0, 2'd2, 32'd0);
        chk(sec64_pulse == 1'b0, "R4 pulse one cycle", 32'(sec64_pulse), 32'd0);
        chk(reg_rdata == 32'd1, "R4 sticky set", reg_rdata, 32'd1);
        step(0, 1, 2'd2, 32'hFFFF_FFFE);
        chk(reg_rdata == 32'd1, "R4 write 0 keeps sticky", reg_rdata, 32'd1);
        step(0, 1, 2'd2, 32'd1);
        chk(reg_rdata == 32'd0, "R4 write 1 clears sticky", reg_rdata, 32'd0);

        // R4: set wins over clear on the same edge
        step(0, 1, 2'd0, ct(127, 7999, 3071));
        step(1, 1, 2'd2, 32'd1);
        chk(reg_rdata == 32'd1, "R4 set beats clear", reg_rdata, 32'd1);

        // R6: bus-time write replaces upper bits only
        step(0, 1, 2'd0, ct(0, 0, 0));
        step(0, 1, 2'd1, 32'hABCD_E0FF);
        chk(reg_rdata == 32'hABCD_E080, "R6 upper bits replaced", reg_rdata, 32'hABCD_E080);

        // R7: cycle write beats tick, keeps upper bus bits
        step(1, 1, 2'd0, ct(5, 100, 200));
        chk(cycle_time == ct(5, 100, 200), "R7 write beats tick", cycle_time, ct(5, 100, 200));
        step(0, 0, 2'd1, 32'd0);
        chk(reg_rdata == 32'hABCD_E085, "R7 upper kept on load", reg_rdata, 32'hABCD_E085);

        // R6: bus-time write on the wrap edge
        step(0, 1, 2'd0, ct(127, 7999, 3071));
        step(1, 1, 2'd1, 32'h1234_5600);
        chk(reg_rdata == 32'h1234_5680, "R6 write then wrap carry", reg_rdata, 32'h1234_5680);

        // R8: spare address write and read
        step(0, 1, 2'd3, 32'hFFFF_FFFF);
        chk(reg_rdata == 32'd0, "R8 spare reads zero", reg_rdata, 32'd0);
        step(0, 0, 2'd1, 32'd0);
        chk(reg_rdata == 32'h1234_5680, "R8 bus time untouched", reg_rdata, 32'h1234_5680);

        // mixed traffic, reads only
        for (int i = 0; i < 300; i++)
            step(1'($urandom % 2), 0, 2'($urandom % 4), 32'd0);

        // R9: reset from a running state
        do_reset(1);
        chk(cycle_time == 32'd0, "R9 mid-run reset word", cycle_time, 32'd0);
        step(0, 0, 2'd1, 32'd0);
        chk(reg_rdata == 32'd0, "R9 mid-run reset bus time", reg_rdata, 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule